// File: doc/BRIEF.md
# Integer Register-Register Execute Unit

This block takes one 32-bit instruction word per cycle, together with a valid strobe, and executes it if it is one of the ten integer register-to-register operations: add, subtract, the three shifts, signed and unsigned set-less-than, and the three bitwise logic operations. The block holds its own register file of 32 entries, each XLEN bits wide. Entry 0 is hard-wired to zero. The two source operands are read combinationally from the entries named by the instruction. The result is computed in the same cycle and written to the destination entry on the next rising clock edge.

The result, the destination index and an illegal-instruction flag are visible at the ports while the instruction is presented. Any word that is not a supported operation raises the illegal flag and does not change the register file. A debug port can read any entry and can also write one, so that operands can be loaded from outside the block. No other path fills the file, because no immediate, load or move instruction is accepted.

Top module: `rr_exec_unit`

## Requirements
- R1: An instruction is accepted only when `instr_word[6:0]` equals 7'b0110011. With `instr_valid` high and any other opcode, `illegal` is 1 and no register changes. With `instr_valid` low, `illegal` is 0.
- R2: The fields are taken from fixed bit positions: destination `[11:7]`, funct3 `[14:12]`, first source `[19:15]`, second source `[24:20]`, funct7 `[31:25]`. Operands are the contents of the selected registers, never the index values. The word 32'h00d60733 is an add with destination 14 and sources 12 and 13.
- R3: Add (funct7 0000000, funct3 000) and subtract (funct7 0100000, funct3 000) keep only the low XLEN bits of the result. Overflow and borrow are discarded.
- R4: Signed less-than (funct7 0000000, funct3 010) treats both operands as two's-complement values and yields 1 if the first is smaller, otherwise 0.
- R5: Unsigned less-than (funct7 0000000, funct3 011) compares the operands as unsigned values. With register 0 as the first source, the result is 1 exactly when the second operand is nonzero.
- R6: With funct7 0000000, funct3 111 gives bitwise AND, 110 gives bitwise OR and 100 gives bitwise XOR.
- R7: Left logical shift (funct7 0000000, funct3 001), right logical shift (funct7 0000000, funct3 101) and right arithmetic shift (funct7 0100000, funct3 101) use only the low log2(XLEN) bits of the second operand as the amount. That is bits [4:0] when XLEN is 32. The arithmetic shift fills vacated bits with bit XLEN-1 of the first operand.
- R8: Any funct7/funct3 pair under the accepted opcode that is not listed in R3 to R7 raises `illegal` and suppresses the write.
- R9: Register 0 always reads as zero. Writes to it, from an instruction or from the debug port, are ignored.
- R10: A legal instruction with `instr_valid` high writes `result` to its destination on the rising clock edge. A dependent instruction in the very next cycle sees the new value. Nothing is written while `instr_valid` is low.
- R11: While `rst_n` is low, every register is cleared to zero and `illegal` is 0.
- R12: When `dbg_we` is high, `dbg_wdata` is written to entry `dbg_idx` on the clock edge. If an instruction writes the same entry on the same edge, the instruction's result is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr_word | input | 32 | Instruction to execute |
| result | output | XLEN | Computed value of the presented instruction |
| result_rd | output | 5 | Destination index of the presented instruction |
| illegal | output | 1 | Presented valid word is not a supported operation |
| dbg_idx | input | 5 | Debug access register index |
| dbg_we | input | 1 | Debug write enable |
| dbg_wdata | input | XLEN | Debug write data |
| dbg_rdata | output | XLEN | Contents of register `dbg_idx` |

## Verification
The bench goes after the encoding corners: subtract and arithmetic shift share funct3 values with add and logical right shift, so a decoder that ignores funct7 would add where it should subtract and zero-fill where it should sign-fill. Operand pairs are chosen so that signed and unsigned less-than give opposite answers, which exposes a swapped comparison. Shift amounts of 32 and above expose a shifter that uses more than the low amount bits. Register 0 is tested as a source to the unsigned compare and as a write target; a design that stores into it would read back nonzero. Illegal words and dropped valids are followed by a readback of the destination, so that a design that still writes would be caught. A back-to-back dependent pair exposes a stale read path.

// File: rtl/rr_pkg.sv
package rr_pkg;

   localparam int          ILEN     = 32;
   localparam int          IDX_W    = 5;
   localparam int          NREG     = 1 << IDX_W;
   localparam logic [6:0]  OPC_REG  = 7'b0110011;
   localparam logic [6:0]  F7_BASE  = 7'b0000000;
   localparam logic [6:0]  F7_ALT   = 7'b0100000;

   typedef enum logic [3:0] {
      OP_ADD,
      OP_SUB,
      OP_SLL,
      OP_SLT,
      OP_SLTU,
      OP_XOR,
      OP_SRL,
      OP_SRA,
      OP_OR,
      OP_AND
   } alu_op_e;

   typedef struct packed {
      alu_op_e          op;
      logic             legal;
      logic [IDX_W-1:0] rd;
      logic [IDX_W-1:0] rs1;
      logic [IDX_W-1:0] rs2;
   } dec_t;

endpackage

// File: rtl/rr_decode.sv
module rr_decode
   import rr_pkg::*;
(
   input  logic [ILEN-1:0] word,
   output dec_t            dec
);

   logic [6:0] opc;
   logic [2:0] f3;
   logic [6:0] f7;

   assign opc = word[6:0];
   assign f3  = word[14:12];
   assign f7  = word[31:25];

   always_comb begin
      dec.rd    = word[11:7];
      dec.rs1   = word[19:15];
      dec.rs2   = word[24:20];
      dec.op    = OP_ADD;
      dec.legal = 1'b0;
      if (opc == OPC_REG) begin
         if (f7 == F7_BASE) begin
            dec.legal = 1'b1;
            unique case (f3)
               3'b000: dec.op = OP_ADD;
               3'b001: dec.op = OP_SLL;
               3'b010: dec.op = OP_SLT;
               3'b011: dec.op = OP_SLTU;
               3'b100: dec.op = OP_XOR;
               3'b101: dec.op = OP_SRL;
               3'b110: dec.op = OP_OR;
               3'b111: dec.op = OP_AND;
               default: dec.legal = 1'b0;
            endcase
         end else if (f7 == F7_ALT) begin
            if (f3 == 3'b000) begin
               dec.op    = OP_SUB;
               dec.legal = 1'b1;
            end else if (f3 == 3'b101) begin
               dec.op    = OP_SRA;
               dec.legal = 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/rr_shifter.sv
module rr_shifter #(
   parameter int XLEN   = 32,
   parameter bit STAGED = 1'b1
) (
   input  logic [XLEN-1:0]         a,
   input  logic [$clog2(XLEN)-1:0] amt,
   input  logic                    go_left,
   input  logic                    arith,
   output logic [XLEN-1:0]         y
);

   localparam int SHW = $clog2(XLEN);

   logic [XLEN-1:0] a_rev;
   logic [XLEN-1:0] r_out;
   logic            fill;

   always_comb begin
      for (int i = 0; i < XLEN; i++) a_rev[i] = a[XLEN-1-i];
   end

   assign fill = arith & ~go_left & a[XLEN-1];

   if (STAGED) begin : g_staged
      logic [XLEN-1:0] stg [SHW+1];
      assign stg[0] = go_left ? a_rev : a;
      for (genvar k = 0; k < SHW; k++) begin : g_stage
         localparam int S = 1 << k;
         assign stg[k+1] = amt[k] ? { {S{fill}}, stg[k][XLEN-1:S] } : stg[k];
      end
      assign r_out = stg[SHW];
   end else begin : g_flat
      logic signed [XLEN:0] ext;
      assign ext   = $signed({fill, (go_left ? a_rev : a)});
      logic signed [XLEN:0] sh;
      assign sh    = ext >>> amt;
      assign r_out = sh[XLEN-1:0];
   end

   always_comb begin
      if (go_left) begin
         for (int i = 0; i < XLEN; i++) y[i] = r_out[XLEN-1-i];
      end else begin
         y = r_out;
      end
   end

endmodule

// File: rtl/rr_alu.sv
module rr_alu
   import rr_pkg::*;
#(
   parameter int XLEN          = 32,
   parameter bit STAGED_SHIFT  = 1'b1
) (
   input  alu_op_e         op,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic [XLEN-1:0] y
);

   localparam int SHW = $clog2(XLEN);

   logic [XLEN-1:0] sum;
   logic [XLEN-1:0] sh_y;
   logic            lt_s;
   logic            lt_u;
   logic            is_sub;

   assign is_sub = (op == OP_SUB);
   assign sum    = a + (is_sub ? ~b : b) + {{(XLEN-1){1'b0}}, is_sub};
   assign lt_s   = $signed(a) < $signed(b);
   assign lt_u   = a < b;

   rr_shifter #(
      .XLEN   (XLEN),
      .STAGED (STAGED_SHIFT)
   ) shifter_i (
      .a       (a),
      .amt     (b[SHW-1:0]),
      .go_left (op == OP_SLL),
      .arith   (op == OP_SRA),
      .y       (sh_y)
   );

   always_comb begin
      unique case (op)
         OP_ADD, OP_SUB:         y = sum;
         OP_SLL, OP_SRL, OP_SRA: y = sh_y;
         OP_SLT:                 y = {{(XLEN-1){1'b0}}, lt_s};
         OP_SLTU:                y = {{(XLEN-1){1'b0}}, lt_u};
         OP_XOR:                 y = a ^ b;
         OP_OR:                  y = a | b;
         OP_AND:                 y = a & b;
         default:                y = '0;
      endcase
   end

endmodule

// File: rtl/rr_regfile.sv
module rr_regfile
   import rr_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] ra_idx,
   output logic [XLEN-1:0]  ra_data,
   input  logic [IDX_W-1:0] rb_idx,
   output logic [XLEN-1:0]  rb_data,
   input  logic [IDX_W-1:0] rc_idx,
   output logic [XLEN-1:0]  rc_data,
   input  logic             wa_en,
   input  logic [IDX_W-1:0] wa_idx,
   input  logic [XLEN-1:0]  wa_data,
   input  logic             wb_en,
   input  logic [IDX_W-1:0] wb_idx,
   input  logic [XLEN-1:0]  wb_data
);

   logic [XLEN-1:0] regs [NREG];

   assign regs[0] = '0;

   for (genvar i = 1; i < NREG; i++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs[i] <= '0;
         end else if (wa_en && wa_idx == IDX_W'(i)) begin
            regs[i] <= wa_data;
         end else if (wb_en && wb_idx == IDX_W'(i)) begin
            regs[i] <= wb_data;
         end
      end
   end

   assign ra_data = regs[ra_idx];
   assign rb_data = regs[rb_idx];
   assign rc_data = regs[rc_idx];

endmodule

// File: rtl/rr_exec_unit.sv
module rr_exec_unit
   import rr_pkg::*;
#(
   parameter int XLEN         = 32,
   parameter bit STAGED_SHIFT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             instr_valid,
   input  logic [ILEN-1:0]  instr_word,
   output logic [XLEN-1:0]  result,
   output logic [IDX_W-1:0] result_rd,
   output logic             illegal,
   input  logic [IDX_W-1:0] dbg_idx,
   input  logic             dbg_we,
   input  logic [XLEN-1:0]  dbg_wdata,
   output logic [XLEN-1:0]  dbg_rdata
);

   if (XLEN < 8 || (XLEN & (XLEN - 1)) != 0) begin : g_bad_xlen
      $error("rr_exec_unit: XLEN must be a power of two of at least 8");
   end

   dec_t            dec;
   logic [XLEN-1:0] op_a;
   logic [XLEN-1:0] op_b;
   logic            commit;

   rr_decode decode_i (
      .word (instr_word),
      .dec  (dec)
   );

   rr_regfile #(
      .XLEN (XLEN)
   ) regfile_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .ra_idx  (dec.rs1),
      .ra_data (op_a),
      .rb_idx  (dec.rs2),
      .rb_data (op_b),
      .rc_idx  (dbg_idx),
      .rc_data (dbg_rdata),
      .wa_en   (commit),
      .wa_idx  (dec.rd),
      .wa_data (result),
      .wb_en   (dbg_we),
      .wb_idx  (dbg_idx),
      .wb_data (dbg_wdata)
   );

   rr_alu #(
      .XLEN         (XLEN),
      .STAGED_SHIFT (STAGED_SHIFT)
   ) alu_i (
      .op (dec.op),
      .a  (op_a),
      .b  (op_b),
      .y  (result)
   );

   assign commit    = instr_valid & dec.legal;
   assign illegal   = instr_valid & ~dec.legal;
   assign result_rd = dec.rd;

endmodule

// File: rtl/rr_exec_chk.sv
module rr_exec_chk
   import rr_pkg::*;
#(
   parameter int XLEN = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             instr_valid,
   input logic [ILEN-1:0]  instr_word,
   input logic [XLEN-1:0]  result,
   input logic             illegal,
   input logic [IDX_W-1:0] dbg_idx,
   input logic             dbg_we,
   input logic [XLEN-1:0]  dbg_rdata
);

   // R1
   opcode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && instr_word[6:0] != OPC_REG) |-> illegal);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |-> !illegal);

   // R9
   zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_idx == '0) |-> (dbg_rdata == '0));

   // R4
   slt_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && !illegal && instr_word[14:12] == 3'b010)
      |-> (result[XLEN-1:1] == '0));

   // R8
   no_illegal_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (illegal && !dbg_we && dbg_idx == instr_word[11:7])
      |=> (dbg_idx != $past(dbg_idx)) || (dbg_rdata == $past(dbg_rdata)));

   // R10
   commit_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && !illegal && instr_word[11:7] != '0 && dbg_idx == instr_word[11:7])
      |=> (dbg_idx != $past(dbg_idx)) || (dbg_rdata == $past(result)));

endmodule

bind rr_exec_unit rr_exec_chk #(.XLEN(XLEN)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .instr_valid (instr_valid),
   .instr_word  (instr_word),
   .result      (result),
   .illegal     (illegal),
   .dbg_idx     (dbg_idx),
   .dbg_we      (dbg_we),
   .dbg_rdata   (dbg_rdata)
);

// File: tb/rr_exec_unit_tb_top.sv
module rr_exec_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [31:0] instr_word = '0;
   logic [31:0] result;
   logic [4:0]  result_rd;
   logic        illegal;
   logic [4:0]  dbg_idx = '0;
   logic        dbg_we = 1'b0;
   logic [31:0] dbg_wdata = '0;
   logic [31:0] dbg_rdata;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   rr_exec_unit dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .instr_valid (instr_valid),
      .instr_word  (instr_word),
      .result      (result),
      .result_rd   (result_rd),
      .illegal     (illegal),
      .dbg_idx     (dbg_idx),
      .dbg_we      (dbg_we),
      .dbg_wdata   (dbg_wdata),
      .dbg_rdata   (dbg_rdata)
   );

   typedef struct packed {
      logic [6:0]  f7;
      logic [2:0]  f3;
      logic [31:0] a;
      logic [31:0] b;
      logic [31:0] exp;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{7'h00, 3'b000, 32'd5,        32'd7,        32'd12},        // R3 add
      '{7'h00, 3'b000, 32'hffffffff, 32'd1,        32'd0},         // R3 wrap
      '{7'h20, 3'b000, 32'd5,        32'd7,        32'hfffffffe},  // R3 sub
      '{7'h00, 3'b010, 32'hffffffff, 32'd1,        32'd1},         // R4
      '{7'h00, 3'b010, 32'd1,        32'hffffffff, 32'd0},         // R4
      '{7'h00, 3'b011, 32'hffffffff, 32'd1,        32'd0},         // R5
      '{7'h00, 3'b011, 32'd1,        32'hffffffff, 32'd1},         // R5
      '{7'h00, 3'b111, 32'hf0f0a5a5, 32'hff00ff00, 32'hf000a500},  // R6 and
      '{7'h00, 3'b110, 32'hf0f0a5a5, 32'hff00ff00, 32'hfff0ffa5},  // R6 or
      '{7'h00, 3'b100, 32'hf0f0a5a5, 32'hff00ff00, 32'h0ff05aa5},  // R6 xor
      '{7'h00, 3'b001, 32'd1,        32'd33,       32'd2},         // R7 sll
      '{7'h00, 3'b101, 32'h80000000, 32'd31,       32'd1},         // R7 srl
      '{7'h20, 3'b101, 32'h80000000, 32'd4,        32'hf8000000},  // R7 sra
      '{7'h20, 3'b101, 32'h40000000, 32'd33,       32'h20000000},  // R7 sra pos
      '{7'h00, 3'b101, 32'hf0000000, 32'd36,       32'h0f000000}   // R7 srl
   };

   function automatic logic [31:0] enc(input logic [6:0] f7, input logic [4:0] rs2,
                                       input logic [4:0] rs1, input logic [2:0] f3,
                                       input logic [4:0] rd);
      return {f7, rs2, rs1, f3, rd, 7'b0110011};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic seed(input logic [4:0] idx, input logic [31:0] val);
      @(negedge clk);
      dbg_we    = 1'b1;
      dbg_idx   = idx;
      dbg_wdata = val;
      @(negedge clk);
      dbg_we    = 1'b0;
   endtask

   task automatic peek(input logic [4:0] idx, output logic [31:0] val);
      dbg_idx = idx;
      #1;
      val = dbg_rdata;
   endtask

   // present a word for one cycle; capture the combinational outputs
   task automatic exec(input logic [31:0] w, output logic [31:0] res,
                       output logic [4:0] rdo, output logic ill);
      @(negedge clk);
      instr_word  = w;
      instr_valid = 1'b1;
      #2;
      res = result;
      rdo = result_rd;
      ill = illegal;
      @(negedge clk);
      instr_valid = 1'b0;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      logic [31:0] v;
      logic [4:0]  rdo;
      logic        ill;

      // R11 reset state
      #2;
      check("R11 illegal in reset", {31'd0, illegal}, 32'd0);
      seed(5'd9, 32'h1234);
      peek(5'd9, v);
      check("R11 write blocked in reset", v, 32'd0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      peek(5'd5, v);
      check("R11 reg clear", v, 32'd0);

      // main vector table
      foreach (VECS[i]) begin
         seed(5'd1, VECS[i].a);
         seed(5'd2, VECS[i].b);
         exec(enc(VECS[i].f7, 5'd2, 5'd1, VECS[i].f3, 5'd3), r, rdo, ill);
         check("R3-R7 vector result", r, VECS[i].exp);
         check("R8 vector legal", {31'd0, ill}, 32'd0);
         peek(5'd3, v);
         check("R10 vector writeback", v, VECS[i].exp);
      end

      // R12 debug write
      seed(5'd12, 32'd10);
      seed(5'd13, 32'd20);
      peek(5'd12, v);
      check("R12 debug write", v, 32'd10);

      // R2 known word
      exec(32'h00d60733, r, rdo, ill);
      check("R2 dest field", {27'd0, rdo}, 32'd14);
      check("R2 sum of contents", r, 32'd30);
      peek(5'd14, v);
      check("R2 x14 written", v, 32'd30);

      // R5 register 0 as first source
      seed(5'd2, 32'd5);
      exec(enc(7'h00, 5'd2, 5'd0, 3'b011, 5'd4), r, rdo, ill);
      check("R5 x0 < nonzero", r, 32'd1);
      seed(5'd2, 32'd0);
      exec(enc(7'h00, 5'd2, 5'd0, 3'b011, 5'd4), r, rdo, ill);
      check("R5 x0 < zero", r, 32'd0);

      // R9 writes to register 0
      seed(5'd1, 32'd77);
      exec(enc(7'h00, 5'd1, 5'd1, 3'b000, 5'd0), r, rdo, ill);
      peek(5'd0, v);
      check("R9 instr write x0 ignored", v, 32'd0);
      seed(5'd0, 32'hdead);
      peek(5'd0, v);
      check("R9 debug write x0 ignored", v, 32'd0);

      // R1 wrong opcode
      seed(5'd3, 32'h5555);
      exec({7'h00, 5'd1, 5'd1, 3'b000, 5'd3, 7'b0010011}, r, rdo, ill);
      check("R1 illegal opcode flag", {31'd0, ill}, 32'd1);
      peek(5'd3, v);
      check("R1 no write", v, 32'h5555);

      // R8 bad funct pairings
      exec(enc(7'h01, 5'd1, 5'd1, 3'b000, 5'd3), r, rdo, ill);
      check("R8 funct7 0000001 flag", {31'd0, ill}, 32'd1);
      exec(enc(7'h20, 5'd1, 5'd1, 3'b001, 5'd3), r, rdo, ill);
      check("R8 alt funct7 with 001 flag", {31'd0, ill}, 32'd1);
      peek(5'd3, v);
      check("R8 no write", v, 32'h5555);

      // R10 valid low: no write
      @(negedge clk);
      instr_word  = enc(7'h00, 5'd1, 5'd1, 3'b000, 5'd3);
      instr_valid = 1'b0;
      #2;
      check("R1 idle illegal low", {31'd0, illegal}, 32'd0);
      @(negedge clk);
      peek(5'd3, v);
      check("R10 no write when idle", v, 32'h5555);

      // R10 back-to-back dependency: x5 = x1 + x1; x6 = x5 + x5
      @(negedge clk);
      instr_word  = enc(7'h00, 5'd1, 5'd1, 3'b000, 5'd5);
      instr_valid = 1'b1;
      @(negedge clk);
      instr_word  = enc(7'h00, 5'd5, 5'd5, 3'b000, 5'd6);
      #2;
      check("R10 dependent result", result, 32'd308);
      @(negedge clk);
      instr_valid = 1'b0;
      peek(5'd6, v);
      check("R10 dependent writeback", v, 32'd308);

      // R12 collision: instruction wins
      @(negedge clk);
      dbg_we      = 1'b1;
      dbg_idx     = 5'd7;
      dbg_wdata   = 32'd55;
      instr_word  = enc(7'h00, 5'd1, 5'd1, 3'b000, 5'd7);
      instr_valid = 1'b1;
      @(negedge clk);
      dbg_we      = 1'b0;
      instr_valid = 1'b0;
      peek(5'd7, v);
      check("R12 instruction wins", v, 32'd154);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule